// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is a synthesizable model of a pipelined synchronous static RAM with a 36-bit word split into four 9-bit byte lanes. Select, write enable, the four active-low lane enables and the address are sampled on every rising clock edge. Write data follows its address by one cycle, so the data bus can turn around after a read without a dead cycle on the control pins.

Captured write data waits in a pending register and is only committed to the array when the next write cycle arrives. An address comparator lets a read of the pending address see the new data, merged lane by lane with the stored word. Read data passes through an output register that loads on the falling clock edge. The shared bidirectional bus is modelled as separate data-in, data-out and drive-enable signals. Drive is gated by an asynchronous active-low output enable, and it is switched off for any write or deselect cycle.

The address width is a parameter. The default is small for simulation; a width of 17 gives the full 128K-word array.

Top module: `lwsram_core`

## Requirements
- R1: While reset is held and in the first cycle after it, `dq_oe` is low.
- R2: A cycle sampled with `cs_n` high leaves the bus undriven until the next rising edge, and it changes no stored word, even with `we_n` low.
- R3: A read (`cs_n` low, `we_n` high) sampled at rising edge N puts the word at that address on `dq_o` from the following falling edge, with `dq_oe` high just before edge N+1 when `oe_n` is low.
- R4: `oe_n` high holds `dq_oe` low at once, without waiting for a clock (dummy read). Lowering `oe_n` restores drive of the registered word without a clock edge.
- R5: A write (`cs_n` and `we_n` low) sampled at edge N takes its data from `dq_i` at edge N+1. `wbe_n[k]` low writes lane k, which is bits 9k+8 down to 9k.
- R6: Lanes whose `wbe_n` bit is high keep their previous contents.
- R7: A read of the address held in the pending register returns the pending lanes merged with the array word. This holds right after the write and after any number of deselect cycles.
- R8: Pending data is committed to the array by the next write cycle. Earlier words then read back correctly once several later writes have passed.
- R9: In the cycle after a write address is sampled, `dq_oe` is low, so external write data never meets driven read data.
- R10: A write with all four `wbe_n` bits high leaves the word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; controls sampled on rising edge, output register loads on falling edge |
| rst_n | input | 1 | Synchronous active-low reset of the control pipeline |
| cs_n | input | 1 | Active-low select |
| we_n | input | 1 | Active-low write enable |
| wbe_n | input | 4 | Active-low per-lane write enables |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_i | input | 36 | Bus value seen by the block (write data) |
| dq_o | output | 36 | Registered read data |
| dq_oe | output | 1 | High when the block drives the bus |

## Verification
The assertions watch bus ownership on every cycle. They confirm that the drive enable stays low after reset, on deselect, during a high `oe_n` and in the cycle after a write address, and that it comes up after every read with `oe_n` low. The data side can only be shown by the directed scenarios. These cover the lane mapping, the preserved lanes, the merge of a partial pending write with the array word, the deferred commit, the no-lane write and the asynchronous return of drive. Each is checked against a reference memory in the bench.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;
    // Operation captured at a rising edge
    typedef enum logic [1:0] {
        CMD_IDLE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_WR   = 2'd2
    } cmd_e;
endpackage

// File: rtl/lwsram_pipe.sv
// Address/control stage plus the pending-write register.
module lwsram_pipe
    import lwsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cs_n,
    input  logic                      we_n,
    input  logic [LANES-1:0]          wbe_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output cmd_e                      s1_cmd,
    output logic [ADDR_W-1:0]         s1_addr,
    output logic                      pend_vld,
    output logic [ADDR_W-1:0]         pend_addr,
    output logic [LANES-1:0]          pend_ben,
    output logic [LANES*LANE_W-1:0]   pend_data,
    output logic                      commit_en
);
    localparam int WORD_W = LANES * LANE_W;

    typedef struct packed {
        cmd_e               cmd;
        logic [ADDR_W-1:0]  a;
        logic [LANES-1:0]   ben;
        logic               pv;
        logic [ADDR_W-1:0]  pa;
        logic [LANES-1:0]   pben;
        logic [WORD_W-1:0]  pd;
    } pipe_t;

    pipe_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cs_n)      st_d.cmd = CMD_IDLE;
        else if (we_n) st_d.cmd = CMD_RD;
        else           st_d.cmd = CMD_WR;
        st_d.a   = addr;
        st_d.ben = ~wbe_n;
        // data of the write sampled one edge earlier lands now
        if (st_q.cmd == CMD_WR) begin
            st_d.pv   = 1'b1;
            st_d.pa   = st_q.a;
            st_d.pben = st_q.ben;
            st_d.pd   = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign s1_cmd    = st_q.cmd;
    assign s1_addr   = st_q.a;
    assign pend_vld  = st_q.pv;
    assign pend_addr = st_q.pa;
    assign pend_ben  = st_q.pben;
    assign pend_data = st_q.pd;
    // old pending word retires at the edge that captures the new one
    assign commit_en = (st_q.cmd == CMD_WR) && st_q.pv;
endmodule

// File: rtl/lwsram_array.sv
// Storage split into independently written lanes.
module lwsram_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [LANES-1:0]          wr_ben,
    input  logic [LANES*LANE_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [LANES*LANE_W-1:0]   rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_ben[g]) begin
                mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
    end
endmodule

// File: rtl/lwsram_outstage.sv
// Pending-data bypass, falling-edge output register and bus drive.
module lwsram_outstage
    import lwsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  cmd_e                      s1_cmd,
    input  logic [ADDR_W-1:0]         s1_addr,
    input  logic [LANES*LANE_W-1:0]   arr_data,
    input  logic                      pend_vld,
    input  logic [ADDR_W-1:0]         pend_addr,
    input  logic [LANES-1:0]          pend_ben,
    input  logic [LANES*LANE_W-1:0]   pend_data,
    input  logic                      oe_n,
    output logic [LANES*LANE_W-1:0]   dq_o,
    output logic                      dq_oe
);
    localparam int WORD_W = LANES * LANE_W;

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] data;
    } out_t;

    out_t out_d, out_q;
    logic               hit;
    logic [WORD_W-1:0]  merged;

    assign hit = pend_vld && (pend_addr == s1_addr);

    for (genvar g = 0; g < LANES; g++) begin : g_merge
        assign merged[g*LANE_W +: LANE_W] = (hit && pend_ben[g])
            ? pend_data[g*LANE_W +: LANE_W]
            : arr_data[g*LANE_W +: LANE_W];
    end

    always_comb begin
        out_d     = out_q;
        out_d.vld = (s1_cmd == CMD_RD);
        if (s1_cmd == CMD_RD) begin
            out_d.data = merged;
        end
    end

    always_ff @(negedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign dq_o  = out_q.data;
    assign dq_oe = out_q.vld && (s1_cmd == CMD_RD) && !oe_n;
endmodule

// File: rtl/lwsram_core.sv
module lwsram_core
    import lwsram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic [3:0]        wbe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              oe_n,
    input  logic [35:0]       dq_i,
    output logic [35:0]       dq_o,
    output logic              dq_oe
);
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    cmd_e               s1_cmd;
    logic [ADDR_W-1:0]  s1_addr;
    logic               pend_vld;
    logic [ADDR_W-1:0]  pend_addr;
    logic [LANES-1:0]   pend_ben;
    logic [WORD_W-1:0]  pend_data;
    logic               commit_en;
    logic [WORD_W-1:0]  arr_data;

    lwsram_pipe #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) pipe_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .we_n      (we_n),
        .wbe_n     (wbe_n),
        .addr      (addr),
        .wdata     (dq_i),
        .s1_cmd    (s1_cmd),
        .s1_addr   (s1_addr),
        .pend_vld  (pend_vld),
        .pend_addr (pend_addr),
        .pend_ben  (pend_ben),
        .pend_data (pend_data),
        .commit_en (commit_en)
    );

    lwsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) array_i (
        .clk     (clk),
        .wr_en   (commit_en),
        .wr_addr (pend_addr),
        .wr_ben  (pend_ben),
        .wr_data (pend_data),
        .rd_addr (s1_addr),
        .rd_data (arr_data)
    );

    lwsram_outstage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) out_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .s1_cmd    (s1_cmd),
        .s1_addr   (s1_addr),
        .arr_data  (arr_data),
        .pend_vld  (pend_vld),
        .pend_addr (pend_addr),
        .pend_ben  (pend_ben),
        .pend_data (pend_data),
        .oe_n      (oe_n),
        .dq_o      (dq_o),
        .dq_oe     (dq_oe)
    );
endmodule

// File: rtl/lwsram_chk.sv
module lwsram_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic we_n,
    input logic oe_n,
    input logic dq_oe
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !dq_oe);

    // R2
    deselect_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cs_n)) |-> !dq_oe);

    // R3
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!cs_n && we_n) && !oe_n) |-> dq_oe);

    // R4
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);

    // R9
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!cs_n && !we_n)) |-> !dq_oe);
endmodule

bind lwsram_core lwsram_chk chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .we_n  (we_n),
    .oe_n  (oe_n),
    .dq_oe (dq_oe)
);

// File: tb/lwsram_core_tb.sv
module lwsram_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;
    localparam int DEPTH      = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n = 1'b1;
    logic              we_n = 1'b1;
    logic [3:0]        wbe_n = 4'hf;
    logic [ADDR_W-1:0] addr = '0;
    logic              oe_n = 1'b0;
    logic [35:0]       dq_i = '0;
    logic [35:0]       dq_o;
    logic              dq_oe;

    logic [35:0] ref_mem [DEPTH];
    int n_vec = 0;
    int n_err = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lwsram_core #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .wbe_n(wbe_n),
        .addr(addr), .oe_n(oe_n), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
    );

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // set controls, let the next rising edge sample them, return 1 ns after it
    task automatic issue(input logic c, input logic w, input logic [3:0] be,
                         input logic [ADDR_W-1:0] a);
        cs_n = c; we_n = w; wbe_n = be; addr = a;
        @(posedge clk);
        #1;
    endtask

    task automatic nop();
        issue(1'b1, 1'b1, 4'hf, '0);
    endtask

    // write: data goes on dq_i for the following edge
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [3:0] be, input logic [35:0] d);
        issue(1'b0, 1'b0, be, a);
        chk("R9 bus released after write address", {35'd0, dq_oe}, 36'd0);
        dq_i = d;
        for (int k = 0; k < 4; k++) begin
            if (!be[k]) ref_mem[a][k*9 +: 9] = d[k*9 +: 9];
        end
    endtask

    // read: check just before the edge that follows the sampling edge
    task automatic rd(input logic [ADDR_W-1:0] a, input string req);
        issue(1'b0, 1'b1, 4'hf, a);
        #(CLK_PERIOD - 2);
        chk(req, dq_o, ref_mem[a]);
        chk({req, " drive"}, {35'd0, dq_oe}, 36'd1);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1;
        chk("R1 drive low in reset", {35'd0, dq_oe}, 36'd0);
        rst_n = 1'b1;
        nop();
        chk("R1 drive low after reset", {35'd0, dq_oe}, 36'd0);
    endtask

    task automatic t_basic();
        wr(8'd3, 4'h0, 36'h9_1234_5678);
        rd(8'd3, "R5 R7 full word readback");
        nop();
        #(CLK_PERIOD - 2);
        chk("R2 deselect leaves bus undriven", {35'd0, dq_oe}, 36'd0);
    endtask

    task automatic t_deselect_write();
        wr(8'd20, 4'h0, 36'hA_AAAA_5555);
        nop();
        cs_n = 1'b1; we_n = 1'b0; wbe_n = 4'h0; addr = 8'd20;
        @(posedge clk); #1;
        dq_i = 36'h0_0000_0000;
        nop();
        rd(8'd20, "R2 deselected write ignored");
    endtask

    task automatic t_lanes();
        wr(8'd10, 4'h0, 36'h0);
        wr(8'd10, 4'b1110, 36'hF_FFFF_FFFF);
        nop();
        rd(8'd10, "R5 lane0 is bits 8..0");
        chk("R5 lane0 value", dq_o, 36'h0_0000_01FF);
        wr(8'd11, 4'h0, 36'h1_1111_1111);
        wr(8'd11, 4'b0101, 36'h2_2222_2222);
        nop();
        rd(8'd11, "R6 lanes 0 and 2 kept");
    endtask

    task automatic t_none();
        wr(8'd12, 4'h0, 36'h3_CAFE_0BEE);
        wr(8'd12, 4'hf, 36'h0_0000_0000);
        nop();
        rd(8'd12, "R10 no-lane write leaves word");
    endtask

    task automatic t_commit();
        wr(8'd30, 4'h0, 36'h1_0000_0030);
        wr(8'd31, 4'h0, 36'h2_0000_0031);
        wr(8'd32, 4'h0, 36'h3_0000_0032);
        rd(8'd32, "R7 bypass of latest write");
        rd(8'd30, "R8 committed word 30");
        rd(8'd31, "R8 committed word 31");
        wr(8'd40, 4'h0, 36'h4_4444_0040);
        nop(); nop(); nop();
        rd(8'd40, "R7 pending kept across deselects");
    endtask

    task automatic t_merge();
        wr(8'd60, 4'h0, 36'h5_5555_5555);
        wr(8'd61, 4'h0, 36'h6_6666_6666);
        wr(8'd60, 4'b1011, 36'hA_BCDE_F012);
        rd(8'd60, "R7 pending lane merged with array");
        nop();
    endtask

    task automatic t_dummy();
        wr(8'd50, 4'h0, 36'h7_0BAD_CAFE);
        nop();
        oe_n = 1'b1;
        issue(1'b0, 1'b1, 4'hf, 8'd50);
        #(CLK_PERIOD - 2);
        chk("R4 dummy read not driven", {35'd0, dq_oe}, 36'd0);
        oe_n = 1'b0;
        #1;
        chk("R4 drive returns without clock", {35'd0, dq_oe}, 36'd1);
        chk("R4 registered data", dq_o, 36'h7_0BAD_CAFE);
    endtask

    task automatic t_stream();
        rd(8'd3,  "R3 stream word 3");
        rd(8'd10, "R3 stream word 10");
        rd(8'd11, "R3 stream word 11");
        rd(8'd12, "R3 stream word 12");
        rd(8'd60, "R3 stream word 60");
        nop();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_vec++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_deselect_write();
        t_lanes();
        t_none();
        t_commit();
        t_merge();
        t_dummy();
        t_stream();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end
endmodule